// File: doc/BRIEF.md
# Configuration Command Sequencer

This block sits between a queue of 32-bit configuration commands and the parallel configuration port of an attached switch device. While the host allows it, the block pops commands from the load FIFO one by one and plays each onto the port. The port has three output buses (two of 7 bits and one of 5 bits), a 4-bit response input, an active-low enable, an active-low update strobe and a port clock that the block generates itself. The block keeps going until the load FIFO is empty.

A command whose readback flag is set makes the sequencer hold the port for a programmable number of port clocks. It then samples the device's 4-bit response and pushes it as one word into a readback FIFO. If the readback FIFO is full at that moment, the word is discarded. A synchronous clear abandons whatever command is in flight and returns the block to idle without producing a readback word. The placement of each bus field and of the readback flag inside the command word is set by parameters. Both FIFOs are outside the block: the load FIFO presents its head word while it is not empty, and a one-cycle read strobe pops it.

Top module: `cfgq_sequencer`

## Requirements
- R1: Out of reset and while idle, `port_en_n` and `port_upd_n` are high and `ld_rd` and `rb_wr` are low.
- R2: `ld_rd` is never asserted while `fetch_en` is low, and no command reaches the port while it is low.
- R3: While `fetch_en` is high, commands are popped and played until the load FIFO is empty, and `ld_rd` never pops an empty FIFO.
- R4: Each command takes three port clocks with `port_en_n` low: first the buses are zero with update high, then the buses carry the fields with update high, then the same fields with `port_upd_n` low. With default parameters, bus A = cmd[6:0], bus B = cmd[13:7], bus C = cmd[18:14]. `port_upd_n` is low only while `port_en_n` is low.
- R5: A command with cmd[31] set is a readback. After the update phase, the port holds enable low and the fields on the buses for `rb_wait`+1 further port clocks. At the end of the last of these, `port_rsp` is sampled. A command with cmd[31] clear produces no readback write.
- R6: Each readback produces exactly one single-cycle `rb_wr` pulse, and `rb_data` carries the sampled response.
- R7: If `rb_full` is high when the response is sampled, no `rb_wr` is issued, and the command still completes on the port.
- R8: A `clr` pulse aborts the command in flight. The port returns to idle (enable high) and no readback word is written for it.
- R9: `port_clk` toggles continuously. The port outputs change only on the clock edge at which `port_clk` falls, unless `clr` was high on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous abort, returns to idle |
| fetch_en | input | 1 | Host permission to pop commands |
| rb_wait | input | 8 | Extra port clocks before the response is sampled (minus one) |
| ld_data | input | 32 | Head word of the load FIFO |
| ld_empty | input | 1 | Load FIFO empty |
| ld_rd | output | 1 | Load FIFO pop strobe |
| rb_full | input | 1 | Readback FIFO full |
| rb_wr | output | 1 | Readback FIFO write strobe |
| rb_data | output | 4 | Readback word |
| port_clk | output | 1 | Generated port clock |
| port_en_n | output | 1 | Active-low port enable |
| port_upd_n | output | 1 | Active-low update strobe |
| port_bus_a | output | 7 | Command bus A |
| port_bus_b | output | 7 | Command bus B |
| port_bus_c | output | 5 | Command bus C |
| port_rsp | input | 4 | Device response |

## Verification
The assertions assume that `ld_data` is stable and valid whenever `ld_empty` is low, that `rb_full` is a level the readback FIFO holds steady between clocks, and that `clr` is a single synchronous pulse. The bench models the load FIFO as a first-word-fall-through queue and pops it only on `ld_rd`. It changes `rb_full`, `port_rsp` and `rb_wait` only while no readback is pending. It raises `clr` for exactly one cycle, timed so that the pulse falls inside a long readback wait.

// File: rtl/cfgq_pkg.sv
package cfgq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ARM  = 3'd1,
      ST_DRV  = 3'd2,
      ST_UPD  = 3'd3,
      ST_WAIT = 3'd4
   } seq_st_e;

   function automatic bit fits(input int lsb, input int w, input int total);
      return (lsb >= 0) && (w > 0) && (lsb + w <= total);
   endfunction

   function automatic bit disjoint(input int l0, input int w0, input int l1, input int w1);
      return (l0 + w0 <= l1) || (l1 + w1 <= l0);
   endfunction

endpackage

// File: rtl/cfgq_tick.sv
module cfgq_tick #(
   parameter int HALF_PER = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic pclk,
   output logic tick
);
   localparam int CW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;

   generate
      if (HALF_PER < 1) begin : g_bad
         $error("cfgq_tick: HALF_PER must be at least 1");
      end else if (HALF_PER == 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pclk <= 1'b0;
            else        pclk <= ~pclk;
         end
         assign tick = pclk;
      end else begin : g_div
         localparam logic [CW-1:0] LAST = CW'(HALF_PER - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               pclk <= 1'b0;
            end else if (cnt == LAST) begin
               cnt  <= '0;
               pclk <= ~pclk;
            end else begin
               cnt  <= cnt + 1'b1;
            end
         end
         assign tick = pclk && (cnt == LAST);
      end
   endgenerate

   // R9: the port clock never sits still for more than one half period
   a_r9_pclk_moves: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !pclk);

endmodule

// File: rtl/cfgq_field_map.sv
module cfgq_field_map #(
   parameter int CMD_W = 32,
   parameter int A_W   = 7,
   parameter int B_W   = 7,
   parameter int C_W   = 5,
   parameter int A_LSB = 0,
   parameter int B_LSB = 7,
   parameter int C_LSB = 14,
   parameter int RB_BIT = 31
) (
   input  logic [CMD_W-1:0] cmd,
   output logic [A_W-1:0]   fa,
   output logic [B_W-1:0]   fb,
   output logic [C_W-1:0]   fc,
   output logic             is_rb
);
   import cfgq_pkg::*;

   generate
      if (!fits(A_LSB, A_W, CMD_W) || !fits(B_LSB, B_W, CMD_W) ||
          !fits(C_LSB, C_W, CMD_W) || !fits(RB_BIT, 1, CMD_W)) begin : g_range
         $error("cfgq_field_map: a field lies outside the command word");
      end
      if (!disjoint(A_LSB, A_W, B_LSB, B_W) || !disjoint(A_LSB, A_W, C_LSB, C_W) ||
          !disjoint(B_LSB, B_W, C_LSB, C_W) || !disjoint(RB_BIT, 1, A_LSB, A_W) ||
          !disjoint(RB_BIT, 1, B_LSB, B_W) || !disjoint(RB_BIT, 1, C_LSB, C_W)) begin : g_overlap
         $error("cfgq_field_map: command fields overlap");
      end
   endgenerate

   assign fa    = cmd[A_LSB +: A_W];
   assign fb    = cmd[B_LSB +: B_W];
   assign fc    = cmd[C_LSB +: C_W];
   assign is_rb = cmd[RB_BIT];

endmodule

// File: rtl/cfgq_sequencer.sv
module cfgq_sequencer #(
   parameter int CMD_W    = 32,
   parameter int A_W      = 7,
   parameter int B_W      = 7,
   parameter int C_W      = 5,
   parameter int RSP_W    = 4,
   parameter int WAIT_W   = 8,
   parameter int A_LSB    = 0,
   parameter int B_LSB    = 7,
   parameter int C_LSB    = 14,
   parameter int RB_BIT   = 31,
   parameter int HALF_PER = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fetch_en,
   input  logic [WAIT_W-1:0] rb_wait,
   input  logic [CMD_W-1:0]  ld_data,
   input  logic              ld_empty,
   output logic              ld_rd,
   input  logic              rb_full,
   output logic              rb_wr,
   output logic [RSP_W-1:0]  rb_data,
   output logic              port_clk,
   output logic              port_en_n,
   output logic              port_upd_n,
   output logic [A_W-1:0]    port_bus_a,
   output logic [B_W-1:0]    port_bus_b,
   output logic [C_W-1:0]    port_bus_c,
   input  logic [RSP_W-1:0]  port_rsp
);
   import cfgq_pkg::*;

   seq_st_e           state;
   logic [CMD_W-1:0]  cmd_q;
   logic [WAIT_W-1:0] wcnt;
   logic              tick;
   logic              rb_wr_q;
   logic [RSP_W-1:0]  rb_data_q;
   logic [A_W-1:0]    fa;
   logic [B_W-1:0]    fb;
   logic [C_W-1:0]    fc;
   logic              is_rb;
   logic              slot_free;
   logic              fetch_go;
   logic              drive_fields;

   cfgq_tick #(.HALF_PER(HALF_PER)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .pclk  (port_clk),
      .tick  (tick)
   );

   cfgq_field_map #(
      .CMD_W(CMD_W), .A_W(A_W), .B_W(B_W), .C_W(C_W),
      .A_LSB(A_LSB), .B_LSB(B_LSB), .C_LSB(C_LSB), .RB_BIT(RB_BIT)
   ) u_map (
      .cmd   (cmd_q),
      .fa    (fa),
      .fb    (fb),
      .fc    (fc),
      .is_rb (is_rb)
   );

   // a new command may start where the previous one ends
   assign slot_free = (state == ST_IDLE) ||
                      (state == ST_UPD  && !is_rb) ||
                      (state == ST_WAIT && wcnt == '0);
   assign fetch_go  = tick && slot_free && fetch_en && !ld_empty && !clr;
   assign ld_rd     = fetch_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cmd_q     <= '0;
         wcnt      <= '0;
         rb_wr_q   <= 1'b0;
         rb_data_q <= '0;
      end else if (clr) begin
         state   <= ST_IDLE;
         rb_wr_q <= 1'b0;
      end else begin
         rb_wr_q <= 1'b0;
         if (tick) begin
            if (fetch_go) begin
               cmd_q <= ld_data;
               state <= ST_ARM;
            end else if (slot_free && !(state == ST_UPD)) begin
               state <= ST_IDLE;
            end
            unique case (state)
               ST_ARM:  state <= ST_DRV;
               ST_DRV:  state <= ST_UPD;
               ST_UPD: if (is_rb) begin
                  wcnt  <= rb_wait;
                  state <= ST_WAIT;
               end else if (!fetch_go) begin
                  state <= ST_IDLE;
               end
               ST_WAIT: if (wcnt == '0) begin
                  rb_data_q <= port_rsp;
                  rb_wr_q   <= !rb_full;
               end else begin
                  wcnt <= wcnt - 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign drive_fields = (state == ST_DRV) || (state == ST_UPD) || (state == ST_WAIT);
   assign port_en_n    = (state == ST_IDLE);
   assign port_upd_n   = (state != ST_UPD);
   assign port_bus_a   = drive_fields ? fa : '0;
   assign port_bus_b   = drive_fields ? fb : '0;
   assign port_bus_c   = drive_fields ? fc : '0;
   assign rb_wr        = rb_wr_q;
   assign rb_data      = rb_data_q;

   // R2: no pop without host permission
   a_r2_fetch_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ld_rd |-> fetch_en);
   // R3: never pop an empty load FIFO
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      ld_rd |-> !ld_empty);
   // R4: update only inside an enabled command
   a_r4_upd_in_en: assert property (@(posedge clk) disable iff (!rst_n)
      !port_upd_n |-> !port_en_n);
   // R6: a readback write is a single-cycle pulse
   a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      rb_wr |=> !rb_wr);
   // R7: nothing is written into a full readback FIFO
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      rb_wr |-> !$past(rb_full));
   // R8: a clear leaves the port idle and writes nothing
   a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (port_en_n && !rb_wr));
   // R9: port outputs move only with the falling port clock
   a_r9_edge_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      ((port_en_n != $past(port_en_n) || port_upd_n != $past(port_upd_n)) && !$past(clr))
         |-> (!port_clk && $past(port_clk)));

endmodule

// File: tb/cfgq_sequencer_bench.sv
module cfgq_sequencer_bench;
   localparam int CLK_PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        fetch_en = 1'b0;
   logic [7:0]  rb_wait = '0;
   logic [31:0] ld_data;
   logic        ld_empty;
   logic        ld_rd;
   logic        rb_full = 1'b0;
   logic        rb_wr;
   logic [3:0]  rb_data;
   logic        port_clk, port_en_n, port_upd_n;
   logic [6:0]  port_bus_a, port_bus_b;
   logic [4:0]  port_bus_c;
   logic [3:0]  port_rsp = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // load FIFO model: head word visible while not empty
   logic [31:0] qmem [0:15];
   int wp = 0;
   int rp = 0;
   assign ld_empty = (wp == rp);
   assign ld_data  = qmem[rp % 16];
   always @(posedge clk) if (ld_rd) rp <= rp + 1;

   // port and readback logs, one record per enabled port clock
   logic [19:0] rec [0:63];
   int nrec = 0;
   logic [3:0] rbw [0:15];
   int nrb = 0;
   always @(negedge clk) begin
      if (port_clk && !port_en_n && nrec < 64) begin
         rec[nrec] <= {port_upd_n, port_bus_a, port_bus_b, port_bus_c};
         nrec <= nrec + 1;
      end
      if (rb_wr && nrb < 16) begin
         rbw[nrb] <= rb_data;
         nrb <= nrb + 1;
      end
   end

   always #(CLK_PER/2) clk = ~clk;

   cfgq_sequencer u_cfgq_sequencer (
      .clk(clk), .rst_n(rst_n), .clr(clr), .fetch_en(fetch_en), .rb_wait(rb_wait),
      .ld_data(ld_data), .ld_empty(ld_empty), .ld_rd(ld_rd),
      .rb_full(rb_full), .rb_wr(rb_wr), .rb_data(rb_data),
      .port_clk(port_clk), .port_en_n(port_en_n), .port_upd_n(port_upd_n),
      .port_bus_a(port_bus_a), .port_bus_b(port_bus_b), .port_bus_c(port_bus_c),
      .port_rsp(port_rsp)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] w);
      @(negedge clk);
      qmem[wp % 16] = w;
      wp = wp + 1;
   endtask

   task automatic clear_logs();
      @(negedge clk);
      nrec = 0;
      nrb  = 0;
   endtask

   // compare the records of one command starting at index idx
   task automatic expect_cmd(input logic [31:0] c, input int waitn, inout int idx, input string req);
      logic [19:0] f;
      f = {1'b0, c[6:0], c[13:7], c[18:14]};
      check(rec[idx] == 20'h80000, {req, " arm phase"}, 32'(rec[idx]), 32'h80000);
      check(rec[idx+1] == (f | 20'h80000), {req, " drive phase"}, 32'(rec[idx+1]), 32'(f | 20'h80000));
      check(rec[idx+2] == f, {req, " update phase"}, 32'(rec[idx+2]), 32'(f));
      idx += 3;
      if (c[31]) begin
         for (int k = 0; k <= waitn; k++) begin
            check(rec[idx] == (f | 20'h80000), {req, " wait phase"}, 32'(rec[idx]), 32'(f | 20'h80000));
            idx++;
         end
      end
   endtask

   task automatic t_reset();
      logic p0;
      check(port_en_n && port_upd_n, "R1 idle strobes", {port_en_n, port_upd_n}, 2'b11);
      check(!ld_rd && !rb_wr, "R1 idle fifo strobes", {ld_rd, rb_wr}, 0);
      @(negedge clk); p0 = port_clk;
      @(negedge clk);
      check(port_clk != p0, "R9 port clock toggles", port_clk, !p0);
   endtask

   task automatic t_disabled_then_drain();
      int idx = 0;
      clear_logs();
      push(32'h0001_2345);
      push(32'h0006_abcd);
      repeat (30) @(negedge clk);
      check(nrec == 0, "R2 no port activity while disabled", nrec, 0);
      check(wp - rp == 2, "R2 fifo untouched while disabled", wp - rp, 2);
      fetch_en = 1'b1;
      repeat (60) @(negedge clk);
      check(wp == rp, "R3 fifo drained", wp - rp, 0);
      check(nrec == 6, "R3 both commands played", nrec, 6);
      expect_cmd(32'h0001_2345, 0, idx, "R4 cmd0");
      expect_cmd(32'h0006_abcd, 0, idx, "R4 cmd1");
      check(nrb == 0, "R5 plain command writes no readback", nrb, 0);
      check(port_en_n, "R1 idle after drain", port_en_n, 1);
   endtask

   task automatic t_readback();
      int idx = 0;
      rb_wait  = 8'd2;
      port_rsp = 4'hA;
      clear_logs();
      push(32'h8004_1f0e);
      repeat (60) @(negedge clk);
      check(nrec == 6, "R5 readback hold length", nrec, 6);
      expect_cmd(32'h8004_1f0e, 2, idx, "R5 readback");
      check(nrb == 1, "R6 one readback word", nrb, 1);
      check(rbw[0] == 4'hA, "R6 readback data", rbw[0], 4'hA);
   endtask

   task automatic t_full();
      rb_full  = 1'b1;
      port_rsp = 4'h5;
      clear_logs();
      push(32'h8000_0077);
      repeat (60) @(negedge clk);
      check(nrb == 0, "R7 word dropped when full", nrb, 0);
      check(nrec == 6, "R7 command still completes", nrec, 6);
      rb_full = 1'b0;
   endtask

   task automatic t_clear();
      rb_wait  = 8'd20;
      port_rsp = 4'h9;
      clear_logs();
      push(32'h8000_1111);
      repeat (20) @(negedge clk);
      check(!port_en_n, "R8 command in flight before clear", port_en_n, 0);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      check(port_en_n, "R8 port idle right after clear", port_en_n, 1);
      repeat (80) @(negedge clk);
      check(nrb == 0, "R8 no readback after abort", nrb, 0);
      check(port_en_n && wp == rp, "R8 stays idle", {port_en_n, 8'(wp - rp)}, 9'h100);
   endtask

   task automatic t_mixed();
      int idx = 0;
      rb_wait  = 8'd0;
      port_rsp = 4'h3;
      fetch_en = 1'b0;
      clear_logs();
      push(32'h0007_ffff);
      push(32'h8002_4081);
      push(32'h0000_0040);
      fetch_en = 1'b1;
      repeat (80) @(negedge clk);
      check(nrec == 10, "R4 mixed record count", nrec, 10);
      expect_cmd(32'h0007_ffff, 0, idx, "R4 mixed a");
      expect_cmd(32'h8002_4081, 0, idx, "R5 mixed b");
      expect_cmd(32'h0000_0040, 0, idx, "R4 mixed c");
      check(nrb == 1 && rbw[0] == 4'h3, "R6 mixed readback", {nrb[3:0], rbw[0]}, 8'h13);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled_then_drain();
      t_readback();
      t_full();
      t_clear();
      t_mixed();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule